// File: doc/BRIEF.md
# USB Serial CRC Generator and Checker

This block carries the cyclic redundancy checks of a full-speed USB serial engine. It takes one bit at a time, in the order the bits appear on the line, and runs two shift registers in parallel. One is the 5-bit token check and the other is the 16-bit data check. A clear pulse at the start of a field presets both registers. A check pulse after the last bit compares the register chosen by a field-type input against its fixed good-packet remainder and reports pass or fail.

On transmit, the 16-bit register takes in the outgoing payload bits. A send pulse then captures its ones' complement into a shifter. The shifter presents the check bits one at a time and steps to the next bit on each bit-valid strobe. The serial engine around the block does the line coding, stuffing, framing and PID handling. That engine supplies the bit-valid strobe, so stuffed bit times simply have no strobe.

Top module: `usb_crc_unit`

## Requirements
- R1: With `fld_is_token`=1, a check pulse sets `chk_ok`=1 when the 5-bit register (polynomial x^5+x^2+1, preset 5'b11111) holds 5'b01100. This holds for any 11 token bits sent LSB first and followed by the complement of their reflected remainder (reflected poly 5'h14, preset 5'h1F), LSB first.
- R2: With `fld_is_token`=0, a check pulse sets `chk_ok`=1 when the 16-bit register (polynomial x^16+x^15+x^2+1, preset 16'hFFFF) holds 16'h800D. This holds for any payload, including an empty one, followed by the complement of its reflected remainder (reflected poly 16'hA001, preset 16'hFFFF), LSB first.
- R3: A field with any single bit inverted gives `chk_ok`=0 on its check pulse, in both field types.
- R4: Bits are taken in only in cycles with `bit_vld`=1. Idle cycles and the value on `bit_in` during them change no result.
- R5: `fld_clr` presets both registers and drives `chk_ok` to 0 in the next cycle. When it comes in the same cycle as `chk_stb`, it wins, and `chk_done` stays 0.
- R6: `chk_done` is high for exactly the one cycle after an accepted `chk_stb`. `chk_ok` takes its new value in that same cycle and keeps it until the next `chk_stb` or `fld_clr`.
- R7: One cycle after `tx_go` (while idle), `tx_act` is 1. `tx_bit` then gives, in order, the 16 bits of the complement of the reflected 16-bit remainder of the bits taken in since the last clear, LSB first.
- R8: The transmit shifter moves one bit per `bit_vld` cycle and drops `tx_act` after the 16th. Bits strobed during emission are not taken into the CRC registers.
- R9: `tx_go` during an emission has no effect on the bit sequence or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| fld_clr | input | 1 | Start of field: preset registers, drop result |
| bit_vld | input | 1 | Bit strobe for receive input and transmit advance |
| bit_in | input | 1 | Line-order data bit |
| fld_is_token | input | 1 | 1: compare 5-bit check, 0: compare 16-bit check |
| chk_stb | input | 1 | End of field: evaluate remainder |
| tx_go | input | 1 | Capture and start emitting the 16-bit check |
| chk_done | output | 1 | One-cycle result pulse |
| chk_ok | output | 1 | Field passed |
| tx_bit | output | 1 | Current outgoing check bit |
| tx_act | output | 1 | Check bits being emitted |

## Verification
There is one register between every control input and every result. `chk_done` and the new `chk_ok` appear one cycle after `chk_stb`, and `fld_clr` clears `chk_ok` in the next cycle. The first check bit is on `tx_bit` one cycle after `tx_go`, and each bit-valid cycle then moves it on by one bit. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so exactly one rising edge falls between stimulus and sample. The expected remainders and check bits come from a reflected (right-shifting) model, which is a different form from the left-shifting registers in the design.

// File: rtl/usb_crc_pkg.sv
package usb_crc_pkg;
   localparam int unsigned TOK_W_DEF = 5;
   localparam int unsigned DAT_W_DEF = 16;
   localparam logic [4:0]  TOK_POLY_DEF = 5'h05;
   localparam logic [4:0]  TOK_RES_DEF  = 5'h0C;
   localparam logic [15:0] DAT_POLY_DEF = 16'h8005;
   localparam logic [15:0] DAT_RES_DEF  = 16'h800D;

   typedef enum logic {
      FLD_DATA  = 1'b0,
      FLD_TOKEN = 1'b1
   } fld_kind_e;
endpackage

// File: rtl/usb_crc_lfsr.sv
module usb_crc_lfsr #(
   parameter int unsigned W       = 16,
   parameter logic [W-1:0] POLY    = 16'h8005,
   parameter logic [W-1:0] INIT    = {W{1'b1}},
   parameter logic [W-1:0] RESIDUE = 16'h800D,
   parameter bit          REFLECT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic         din,
   output logic [W-1:0] norm,
   output logic         hit
);
   if (W < 2) begin : g_bad_w
      $error("usb_crc_lfsr: W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("usb_crc_lfsr: POLY needs its constant term");
   end

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] o;
      for (int i = 0; i < W; i++) o[i] = v[W-1-i];
      return o;
   endfunction

   if (REFLECT == 1'b0) begin : g_left
      logic [W-1:0] r;
      logic         fb;
      assign fb = din ^ r[W-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   r <= INIT;
         else if (clr) r <= INIT;
         else if (adv) r <= {r[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
      end
      assign norm = r;
   end else begin : g_right
      localparam logic [W-1:0] RPOLY = flip(POLY);
      localparam logic [W-1:0] RINIT = flip(INIT);
      logic [W-1:0] rr;
      logic         fb;
      assign fb = din ^ rr[0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   rr <= RINIT;
         else if (clr) rr <= RINIT;
         else if (adv) rr <= {1'b0, rr[W-1:1]} ^ ({W{fb}} & RPOLY);
      end
      assign norm = flip(rr);
   end

   assign hit = (norm == RESIDUE);

   AST_CLR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (norm == INIT)); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(norm)); // R4
endmodule

// File: rtl/usb_crc_txshift.sv
module usb_crc_txshift #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         adv,
   input  logic [W-1:0] fcs,
   output logic         bit_o,
   output logic         act
);
   localparam int unsigned CW = $clog2(W + 1);
   localparam logic [CW-1:0] FULL = CW'(W);

   if (W < 2) begin : g_bad_w
      $error("usb_crc_txshift: W must be at least 2");
   end

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;

   assign act   = (cnt != '0);
   assign bit_o = sh[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (!act) begin
         if (load) begin
            sh  <= fcs;
            cnt <= FULL;
         end
      end else if (adv) begin
         sh  <= {sh[W-2:0], 1'b0};
         cnt <= cnt - CW'(1);
      end
   end

   AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !act) |=> act); // R7
   AST_TX_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !adv) |=> (act && $stable(bit_o))); // R8
   AST_TX_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (act && load && !adv) |=> $stable(cnt)); // R9
   AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (act && adv) |=> (cnt == $past(cnt) - CW'(1))); // R8
endmodule

// File: rtl/usb_crc_unit.sv
module usb_crc_unit
   import usb_crc_pkg::*;
#(
   parameter int unsigned TOK_W    = TOK_W_DEF,
   parameter int unsigned DAT_W    = DAT_W_DEF,
   parameter logic [TOK_W-1:0] TOK_POLY = TOK_POLY_DEF,
   parameter logic [TOK_W-1:0] TOK_RES  = TOK_RES_DEF,
   parameter logic [DAT_W-1:0] DAT_POLY = DAT_POLY_DEF,
   parameter logic [DAT_W-1:0] DAT_RES  = DAT_RES_DEF,
   parameter bit          REFLECT  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fld_clr,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic fld_is_token,
   input  logic chk_stb,
   input  logic tx_go,
   output logic chk_done,
   output logic chk_ok,
   output logic tx_bit,
   output logic tx_act
);
   localparam logic [TOK_W-1:0] TOK_INIT = {TOK_W{1'b1}};
   localparam logic [DAT_W-1:0] DAT_INIT = {DAT_W{1'b1}};

   if (TOK_W >= DAT_W) begin : g_bad_widths
      $error("usb_crc_unit: token check must be narrower than data check");
   end

   logic              absorb;
   logic [TOK_W-1:0]  tok_reg;
   logic [DAT_W-1:0]  dat_reg;
   logic              tok_hit;
   logic              dat_hit;
   logic              sel_hit;
   fld_kind_e         kind;
   logic              done_q;
   logic              ok_q;

   assign absorb = bit_vld & ~tx_act;
   assign kind   = fld_kind_e'(fld_is_token);

   usb_crc_lfsr #(
      .W(TOK_W), .POLY(TOK_POLY), .INIT(TOK_INIT), .RESIDUE(TOK_RES), .REFLECT(REFLECT)
   ) u_tok (
      .clk(clk), .rst_n(rst_n), .clr(fld_clr), .adv(absorb), .din(bit_in),
      .norm(tok_reg), .hit(tok_hit)
   );

   usb_crc_lfsr #(
      .W(DAT_W), .POLY(DAT_POLY), .INIT(DAT_INIT), .RESIDUE(DAT_RES), .REFLECT(REFLECT)
   ) u_dat (
      .clk(clk), .rst_n(rst_n), .clr(fld_clr), .adv(absorb), .din(bit_in),
      .norm(dat_reg), .hit(dat_hit)
   );

   usb_crc_txshift #(.W(DAT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_go), .adv(bit_vld),
      .fcs(~dat_reg), .bit_o(tx_bit), .act(tx_act)
   );

   always_comb begin
      case (kind)
         FLD_TOKEN: sel_hit = tok_hit;
         default:   sel_hit = dat_hit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         done_q <= chk_stb & ~fld_clr;
         if (fld_clr)      ok_q <= 1'b0;
         else if (chk_stb) ok_q <= sel_hit;
      end
   end

   assign chk_done = done_q;
   assign chk_ok   = ok_q;

   logic unused_regs;
   assign unused_regs = ^{tok_reg};

   AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_stb && !fld_clr) |=> chk_done); // R6
   AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_stb || fld_clr) |=> !chk_done); // R5
   AST_CLR_DROPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
      fld_clr |=> !chk_ok); // R5
   AST_OK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_stb && !fld_clr) |=> $stable(chk_ok)); // R6
   AST_TX_NO_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_act && !fld_clr) |=> $stable(dat_reg)); // R8
endmodule

// File: tb/tb_usb_crc_unit.sv
`timescale 1ns/1ps
module tb_usb_crc_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fld_clr = 0, bit_vld = 0, bit_in = 0, fld_is_token = 0, chk_stb = 0, tx_go = 0;
   logic chk_done, chk_ok, tx_bit, tx_act;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   usb_crc_unit dut (
      .clk(clk), .rst_n(rst_n), .fld_clr(fld_clr), .bit_vld(bit_vld), .bit_in(bit_in),
      .fld_is_token(fld_is_token), .chk_stb(chk_stb), .tx_go(tx_go),
      .chk_done(chk_done), .chk_ok(chk_ok), .tx_bit(tx_bit), .tx_act(tx_act)
   );

   function automatic logic [15:0] m16(input logic [15:0] c, input logic b);
      logic fb = c[0] ^ b;
      c = c >> 1;
      if (fb) c = c ^ 16'hA001;
      return c;
   endfunction

   function automatic logic [4:0] m5(input logic [4:0] c, input logic b);
      logic fb = c[0] ^ b;
      c = c >> 1;
      if (fb) c = c ^ 5'h14;
      return c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_field();
      fld_clr = 1; @(negedge clk); fld_clr = 0;
   endtask

   task automatic feed(input logic b);
      bit_vld = 1; bit_in = b; @(negedge clk); bit_vld = 0;
   endtask

   task automatic strobe(input logic tok, input logic exp_ok, input string req);
      fld_is_token = tok; chk_stb = 1; @(negedge clk); chk_stb = 0;
      check(req, chk_done, 1);
      check(req, chk_ok, exp_ok);
   endtask

   // token of 11 bits, optional flipped bit index (-1 for none)
   task automatic run_token(input logic [10:0] tok, input int flip, input logic exp_ok, input string req);
      logic [15:0] st;
      logic [4:0] m = 5'h1F;
      for (int i = 0; i < 11; i++) begin st[i] = tok[i]; m = m5(m, tok[i]); end
      for (int i = 0; i < 5; i++) st[11+i] = ~m[i];
      if (flip >= 0) st[flip] = ~st[flip];
      clr_field();
      for (int i = 0; i < 16; i++) feed(st[i]);
      strobe(1'b1, exp_ok, req);
   endtask

   task automatic run_data(input int nbytes, input int seed, input int flip, input bit gaps,
                           input logic exp_ok, input string req);
      logic st[0:279];
      logic [15:0] m = 16'hFFFF;
      int n = 0;
      for (int k = 0; k < nbytes; k++) begin
         logic [7:0] by = 8'((k * 37 + seed * 11 + 5) ^ (k << 3));
         for (int i = 0; i < 8; i++) begin st[n] = by[i]; m = m16(m, by[i]); n++; end
      end
      for (int i = 0; i < 16; i++) begin st[n] = ~m[i]; n++; end
      if (flip >= 0) st[flip] = ~st[flip];
      clr_field();
      for (int i = 0; i < n; i++) begin
         feed(st[i]);
         if (gaps && (i % 3 == 0)) begin
            bit_in = ~bit_in; @(negedge clk); bit_in = ~bit_in; @(negedge clk);
         end
      end
      strobe(1'b0, exp_ok, req);
   endtask

   task automatic t_reset();
      check("R6 reset done", chk_done, 0);
      check("R6 reset ok", chk_ok, 0);
      check("R8 reset tx_act", tx_act, 0);
   endtask

   task automatic t_tokens();
      run_token(11'h715, -1, 1'b1, "R1 token a");
      run_token(11'h000, -1, 1'b1, "R1 token zero");
      run_token(11'h7FF, -1, 1'b1, "R1 token ones");
      run_token(11'h715, 3, 1'b0, "R3 token data bit flipped");
      run_token(11'h2A3, 13, 1'b0, "R3 token crc bit flipped");
   endtask

   task automatic t_data();
      run_data(0, 1, -1, 0, 1'b1, "R2 empty payload");
      run_data(1, 2, -1, 0, 1'b1, "R2 one byte");
      run_data(8, 3, -1, 0, 1'b1, "R2 eight bytes");
      run_data(8, 3, 20, 0, 1'b0, "R3 data bit flipped");
      run_data(4, 4, 37, 0, 1'b0, "R3 crc bit flipped");
      run_data(5, 5, -1, 1, 1'b1, "R4 idle gaps with toggling input");
   endtask

   task automatic t_hold_and_clear();
      run_data(3, 6, -1, 0, 1'b1, "R2 before hold");
      repeat (4) @(negedge clk);
      check("R6 done is one cycle", chk_done, 0);
      check("R6 ok held", chk_ok, 1);
      fld_clr = 1; @(negedge clk); fld_clr = 0;
      check("R5 clear drops ok", chk_ok, 0);
      run_data(3, 6, -1, 0, 1'b1, "R2 again");
      fld_clr = 1; chk_stb = 1; fld_is_token = 0; @(negedge clk);
      fld_clr = 0; chk_stb = 0;
      check("R5 clear wins done", chk_done, 0);
      check("R5 clear wins ok", chk_ok, 0);
      // registers preset: an empty data field with its check bits must pass
      run_data(0, 9, -1, 0, 1'b1, "R5 preset gives empty pass");
   endtask

   task automatic t_tx();
      logic [15:0] m = 16'hFFFF;
      logic [15:0] exp;
      clr_field();
      for (int k = 0; k < 6; k++) begin
         logic [7:0] by = 8'(8'hC3 + k * 29);
         for (int i = 0; i < 8; i++) begin feed(by[i]); m = m16(m, by[i]); end
      end
      exp = ~m;
      tx_go = 1; @(negedge clk); tx_go = 0;
      for (int i = 0; i < 16; i++) begin
         check("R7 tx_act during emission", tx_act, 1);
         check("R7 tx bit", tx_bit, exp[i]);
         if (i == 6) begin
            tx_go = 1; bit_in = ~bit_in; @(negedge clk); tx_go = 0;
            check("R9 tx_go ignored, bit held", tx_bit, exp[i]);
            check("R8 no advance without strobe", tx_act, 1);
         end
         feed(~exp[i]);
      end
      check("R8 tx_act drops after 16", tx_act, 0);
      // emission bits were not absorbed: feeding the check now completes a good field
      for (int i = 0; i < 16; i++) feed(exp[i]);
      strobe(1'b0, 1'b1, "R8 loopback residue after emission");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tokens();
      t_data();
      t_hold_and_clear();
      t_tx();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule